// File: doc/BRIEF.md
# Fractional-N Clock Divider with Cascaded Noise-Shaping Modulator

This block divides a fast input clock by a programmable ratio that need not be an integer. The ratio is given as an integer part `N` and a 16-bit binary fraction `F`, so the target ratio is N + F/65536. A programmable down-counter produces each output period. Once per output period, at the reload, a cascade of first-order accumulators works out a small signed offset. The counter's next modulus is `N` plus that offset. Over many periods, the average modulus converges to the programmed ratio. The quantisation error is pushed to high frequencies, so it is not a plain two-value toggle.

The modulator order is selectable from one to four. At order n, the instantaneous modulus moves over 2^n neighbouring integers around `N`. The divided clock is high for the first half of each period, rounded down, and low for the rest. This suits the feedback input of a phase-frequency detector. The modulus of the period in progress is exposed on its own port.

Top module: `mash_frac_div`

The counter runs through two named states. `PH_HIGH` is the high half of a period: it counts down and moves to `PH_LOW` on its last high cycle. `PH_LOW` is the low half: it counts down and, at the terminal count, reloads the counter, steps the modulator and returns to `PH_HIGH`. Reset enters `PH_HIGH` with the counter loaded from `N`.

## Requirements
- R1: A synchronous reset clears all modulator state, holds `clk_o` high and loads `mod_o` with `N`. The first period after reset lasts exactly `N` input cycles.
- R2: Each output period lasts exactly the value `mod_o` shows in its first cycle, and `mod_o` holds that value for the whole period.
- R3: In a period of modulus M, `clk_o` is high for the first floor(M/2) input cycles and low for the remaining cycles.
- R4: Order code `order_i` = k (0 to 3) selects modulator order n = k+1. Every modulus lies in the range N−(2^k−1) to N+2^k inclusive.
- R5: With `F` = 0, every period lasts exactly `N` cycles at every order.
- R6: At order one (code 0), every modulus is `N` or `N+1`. Over the K periods that follow the first period after reset, the moduli sum to exactly K·N + floor(K·F/65536).
- R7: At orders two to four (codes 1 to 3), the moduli of those K periods sum to K·N + floor(K·F/65536) plus an error between −3 and +4. The error comes only from the differentiated higher-stage carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| int_i | input | INT_W | Integer part N of the ratio; must be at least 2^n for order n |
| frac_i | input | ACC_W | Fractional part F, in units of 2^-ACC_W |
| order_i | input | 2 | Modulator order minus one |
| clk_o | output | 1 | Divided output clock |
| mod_o | output | INT_W+1 | Modulus of the period in progress |

## Verification
The properties assume that `int_i`, `frac_i` and `order_i` stay constant between resets. The range and period checks compare against the values present at reset. They also assume that `int_i` is at least 2^n, so the smallest modulus is at least two and both halves of a period exist. The stimulus asserts reset whenever it programs a new setting and only uses integer parts that meet the order's lower bound. This includes the bound itself at orders one and four.

// File: rtl/mash_pkg.sv
package mash_pkg;

    // Highest modulator order the cascade supports.
    localparam int MAX_ORDER = 4;
    // Signed width of the noise-shaped offset (range -7..+8 fits in 6 bits).
    localparam int OFF_W     = 6;

    typedef enum logic [0:0] {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_t;

    typedef logic signed [OFF_W-1:0] offset_t;

    // Widen one carry bit into a signed offset term.
    function automatic offset_t bit_term(input logic b);
        return offset_t'({{(OFF_W-1){1'b0}}, b});
    endfunction

endpackage

// File: rtl/mash_accum.sv
module mash_accum #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         step_i,
    input  logic         active_i,
    input  logic [W-1:0] addend_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    logic [W-1:0] acc_q;
    logic [W:0]   total;

    assign total   = {1'b0, acc_q} + {1'b0, addend_i};
    assign sum_o   = active_i ? total[W-1:0] : '0;
    assign carry_o = active_i & total[W];

    always_ff @(posedge clk_i) begin
        if (rst_i || !active_i) begin
            acc_q <= '0;
        end else if (step_i) begin
            acc_q <= total[W-1:0];
        end
    end

endmodule

// File: rtl/mash_shaper.sv
module mash_shaper
    import mash_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 step_i,
    input  logic [MAX_ORDER-1:0] carry_i,
    output offset_t              offset_o
);

    // Delayed copies of carries two, three and four.
    logic c2_d1;
    logic c3_d1, c3_d2;
    logic c4_d1, c4_d2, c4_d3;

    offset_t term1, term2, term3, term4;

    always_comb begin
        term1 = bit_term(carry_i[0]);
        // first difference of carry two
        term2 = bit_term(carry_i[1]) - bit_term(c2_d1);
        // second difference of carry three
        term3 = bit_term(carry_i[2]) - bit_term(c3_d1) - bit_term(c3_d1)
              + bit_term(c3_d2);
        // third difference of carry four
        term4 = bit_term(carry_i[3])
              - bit_term(c4_d1) - bit_term(c4_d1) - bit_term(c4_d1)
              + bit_term(c4_d2) + bit_term(c4_d2) + bit_term(c4_d2)
              - bit_term(c4_d3);
        offset_o = term1 + term2 + term3 + term4;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
            c4_d1 <= 1'b0;
            c4_d2 <= 1'b0;
            c4_d3 <= 1'b0;
        end else if (step_i) begin
            c2_d1 <= carry_i[1];
            c3_d1 <= carry_i[2];
            c3_d2 <= c3_d1;
            c4_d1 <= carry_i[3];
            c4_d2 <= c4_d1;
            c4_d3 <= c4_d2;
        end
    end

endmodule

// File: rtl/frac_div_fsm.sv
module frac_div_fsm
    import mash_pkg::*;
#(
    parameter int MOD_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [MOD_W-1:0] init_mod_i,
    input  logic [MOD_W-1:0] next_mod_i,
    output logic             clk_o,
    output logic             step_o,
    output logic [MOD_W-1:0] mod_o
);

    phase_t           state_q;
    logic [MOD_W-1:0] cnt_q;
    logic [MOD_W-1:0] cur_mod_q;
    logic [MOD_W-1:0] hi_last;

    // Count value on the last high cycle: M - floor(M/2) + 1.
    assign hi_last = cur_mod_q - (cur_mod_q >> 1) + MOD_W'(1);
    assign mod_o   = cur_mod_q;

    // State register and counter.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= PH_HIGH;
            cnt_q     <= init_mod_i;
            cur_mod_q <= init_mod_i;
        end else begin
            unique case (state_q)
                PH_HIGH: begin
                    cnt_q <= cnt_q - MOD_W'(1);
                    if (cnt_q == hi_last) begin
                        state_q <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == MOD_W'(1)) begin
                        cnt_q     <= next_mod_i;
                        cur_mod_q <= next_mod_i;
                        state_q   <= PH_HIGH;
                    end else begin
                        cnt_q <= cnt_q - MOD_W'(1);
                    end
                end
                default: state_q <= PH_HIGH;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        clk_o  = 1'b0;
        step_o = 1'b0;
        unique case (state_q)
            PH_HIGH: clk_o  = 1'b1;
            PH_LOW:  step_o = (cnt_q == MOD_W'(1));
            default: clk_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/mash_frac_div.sv
module mash_frac_div
    import mash_pkg::*;
#(
    parameter int INT_W = 8,
    parameter int ACC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [INT_W-1:0] int_i,
    input  logic [ACC_W-1:0] frac_i,
    input  logic [1:0]       order_i,
    output logic             clk_o,
    output logic [INT_W:0]   mod_o
);

    localparam int MOD_W = INT_W + 1;
    localparam int SUM_W = MOD_W + 1;

    logic                 step;
    logic [ACC_W-1:0]     stage_sum [MAX_ORDER];
    logic [MAX_ORDER-1:0] carries;
    offset_t              offset;
    logic signed [SUM_W-1:0] mod_wide;
    logic [MOD_W-1:0]     next_mod;

    for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
        logic [ACC_W-1:0] addend;
        logic             active;
        if (k == 0) begin : g_first
            assign addend = frac_i;
        end else begin : g_later
            assign addend = stage_sum[k-1];
        end
        assign active = (order_i >= 2'(k));
        mash_accum #(.W(ACC_W)) u_acc (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .step_i   (step),
            .active_i (active),
            .addend_i (addend),
            .sum_o    (stage_sum[k]),
            .carry_o  (carries[k])
        );
    end

    mash_shaper u_shaper (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .step_i   (step),
        .carry_i  (carries),
        .offset_o (offset)
    );

    assign mod_wide = $signed({2'b00, int_i})
                    + SUM_W'(offset);
    assign next_mod = mod_wide[MOD_W-1:0];

    frac_div_fsm #(.MOD_W(MOD_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .init_mod_i ({1'b0, int_i}),
        .next_mod_i (next_mod),
        .clk_o      (clk_o),
        .step_o     (step),
        .mod_o      (mod_o)
    );

endmodule

// File: rtl/mash_frac_div_chk.sv
module mash_frac_div_chk #(
    parameter int INT_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [INT_W-1:0] int_i,
    input logic [1:0]       order_i,
    input logic             clk_o,
    input logic [INT_W:0]   mod_o
);

    localparam int LW = INT_W + 2;

    logic [LW-1:0] len_q;
    logic [LW-1:0] hi_q;
    logic [LW-1:0] saved_q;
    logic [LW-1:0] span_hi;
    logic [LW-1:0] span_lo;
    logic          clk_d;

    assign span_hi = LW'(1) << order_i;
    assign span_lo = span_hi - LW'(1);

    always_ff @(posedge clk_i) begin
        clk_d <= clk_o;
        if (rst_i) begin
            len_q   <= '0;
            hi_q    <= '0;
            saved_q <= LW'(int_i);
        end else if (clk_o && !clk_d) begin
            len_q   <= LW'(1);
            hi_q    <= LW'(1);
            saved_q <= LW'(mod_o);
        end else begin
            len_q <= len_q + LW'(1);
            if (clk_o) begin
                hi_q <= hi_q + LW'(1);
            end
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (clk_o && mod_o == (INT_W+1)'(int_i)));

    assert_period_len_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(clk_o) |-> (len_q == saved_q));

    assert_high_len_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(clk_o) |-> (hi_q == (saved_q >> 1)));

    assert_mod_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (LW'(mod_o) + span_lo >= LW'(int_i)) && (LW'(mod_o) <= LW'(int_i) + span_hi));

endmodule

bind mash_frac_div mash_frac_div_chk #(.INT_W(INT_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .int_i   (int_i),
    .order_i (order_i),
    .clk_o   (clk_o),
    .mod_o   (mod_o)
);

// File: tb/mash_frac_div_tb.sv
module mash_frac_div_tb;

    localparam int CLK_PERIOD = 10;
    localparam int K          = 256;
    localparam int NV         = 12;

    // {N[7:0], F[15:0], order code[1:0]}
    localparam logic [25:0] VEC [NV] = '{
        {8'd10, 16'h4000, 2'd0},
        {8'd7,  16'h8000, 2'd0},
        {8'd2,  16'h8000, 2'd0},
        {8'd3,  16'hC000, 2'd0},
        {8'd16, 16'h0000, 2'd3},
        {8'd6,  16'h0000, 2'd1},
        {8'd5,  16'h6000, 2'd1},
        {8'd8,  16'h5555, 2'd2},
        {8'd9,  16'hA3D7, 2'd2},
        {8'd16, 16'hFFFF, 2'd3},
        {8'd20, 16'h1234, 2'd3},
        {8'd16, 16'h0001, 2'd3}
    };

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic [7:0] int_i = 8'd10;
    logic [15:0] frac_i = '0;
    logic [1:0] order_i = '0;
    logic       clk_o;
    logic [8:0] mod_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    mash_frac_div u_dut (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .int_i   (int_i),
        .frac_i  (frac_i),
        .order_i (order_i),
        .clk_o   (clk_o),
        .mod_o   (mod_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input int n, input int f, input int o);
        int plen, phigh, pmod, done, sum;
        int bad_len, bad_hi, bad_rng, bad_set, bad_zero, first_len;
        int lo, hi, exp_sum, err;
        logic prev;
        @(negedge clk_i);
        rst_i = 1'b1; int_i = 8'(n); frac_i = 16'(f); order_i = 2'(o);
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_i = 1'b0;
        #1;
        lo = n - ((1 << o) - 1);
        hi = n + (1 << o);
        plen = 0; phigh = 0; pmod = 0; done = 0; sum = 0; prev = 1'b0;
        bad_len = 0; bad_hi = 0; bad_rng = 0; bad_set = 0; bad_zero = 0; first_len = 0;
        while (done <= K) begin
            if (clk_o && !prev) begin
                if (plen > 0) begin
                    if (done == 0) first_len = plen;
                    else sum += plen;
                    if (plen != pmod) bad_len++;
                    if (phigh != plen / 2) bad_hi++;
                    if (plen < lo || plen > hi) bad_rng++;
                    if (o == 0 && plen != n && plen != n + 1) bad_set++;
                    if (f == 0 && plen != n) bad_zero++;
                    done++;
                end
                plen = 1; phigh = 1; pmod = int'(mod_o);
            end else begin
                plen++;
                if (clk_o) phigh++;
            end
            prev = clk_o;
            @(posedge clk_i);
            #1;
        end
        check(first_len == n, "R1 first period", first_len, n);
        check(bad_len == 0, "R2 period vs mod_o mismatches", bad_len, 0);
        check(bad_hi == 0, "R3 high-time mismatches", bad_hi, 0);
        check(bad_rng == 0, "R4 out-of-range moduli", bad_rng, 0);
        if (f == 0) check(bad_zero == 0, "R5 periods differing from N", bad_zero, 0);
        exp_sum = K * n + ((K * f) >>> 16);
        err = sum - exp_sum;
        if (o == 0) begin
            check(bad_set == 0, "R6 moduli outside {N,N+1}", bad_set, 0);
            check(err == 0, "R6 modulus sum", sum, exp_sum);
        end else begin
            check(err >= -3 && err <= 4, "R7 modulus sum", sum, exp_sum);
        end
    endtask

    initial begin
        for (int i = 0; i < NV; i++) begin
            run_vec(int'(VEC[i][25:18]), int'(VEC[i][17:2]), int'(VEC[i][1:0]));
        end

        // Directed: reset in the middle of a run (R1).
        @(negedge clk_i);
        rst_i = 1'b0; int_i = 8'd17; frac_i = 16'h7777; order_i = 2'd3;
        repeat (137) @(posedge clk_i);
        @(negedge clk_i);
        rst_i = 1'b1;
        @(posedge clk_i);
        #1;
        check(mod_o == 9'd17, "R1 mod_o during reset", int'(mod_o), 17);
        check(clk_o == 1'b1, "R1 clk_o during reset", int'(clk_o), 1);
        // Directed: reset state taken from a newly programmed N (R1).
        @(negedge clk_i);
        int_i = 8'd33;
        @(posedge clk_i);
        #1;
        check(mod_o == 9'd33, "R1 mod_o reloads N in reset", int'(mod_o), 33);
        run_vec(33, 16'h7777, 3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule